// File: doc/BRIEF.md
# UART Flag and Interrupt Status Register Block

This block gathers the status of a serial port into one register word. It also drives the port's interrupt line. The receive and transmit engines supply two kinds of input. The first kind is live levels: data waiting, line quiet, buffer space, clear-to-send, transmitter shut down and break present. The second kind is single-cycle event pulses: overflow, start bit seen, framing error, parity error and noise. Live levels appear in the status word as they are. Event pulses, and any change in the clear-to-send or break level, set sticky flags. A sticky flag stays set until software writes a one to its bit.

An interrupt enable mask decides which flags can raise the interrupt. Software changes the mask through two write-one ports: one sets enable bits and the other clears them. A second read-only word shows only the flags that are enabled. The interrupt output is high while any bit of that word is high. This is the only way to silence a read-only level such as buffer space as an interrupt source.

Access is through a simple synchronous write port. The read data is combinational from the address.

Top module: `uart_flag_regs`

## Requirements
- R1: After reset, every sticky flag (bits 5, 8, 11, 12, 13, 14, 15) is 0, the enable mask is 0, and `irqOut` is 0.
- R2: The status word at offset 0x08 shows the live inputs in the same cycle and cannot be written: rx data waiting at bit 0, rx line quiet at bit 1, tx buffer space at bit 2, tx line quiet at bit 3, clear-to-send level at bit 4, transmitter shut down at bit 6, break present at bit 10.
- R3: A pulse on overflow, start, framing, parity or noise sets bit 8, 12, 13, 14 or 15 at the next clock edge. The bit then stays set until it is cleared.
- R4: Bit 5 sets when the clear-to-send level differs from its value on the previous cycle, and bit 11 sets when the break level does. The first cycle after reset never sets bit 5.
- R5: Writing 0x08 clears each sticky bit whose write-data bit is 1. Sticky bits written with 0 keep their value.
- R6: If a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: A write of 1s to 0x0C sets those enable bits, and a write of 1s to 0x10 clears them. A read of either offset returns the mask. Only bits 0, 2, 5, 6, 8 and 11–15 can be enabled (mask 0xF965).
- R8: Offset 0x24 reads the status word ANDed with the enable mask. Writes to 0x24 change nothing.
- R9: `irqOut` is 1 exactly when the word at 0x24 is non-zero.
- R10: Reserved bits (7, 9, 16–31) and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` |
| rxDataWaiting | input | 1 | Receiver holds an unread character |
| rxLineQuiet | input | 1 | Receiver is not inside a character |
| txBufSpace | input | 1 | Transmit buffer can accept data |
| txLineQuiet | input | 1 | Transmitter is not sending |
| ctsLevel | input | 1 | Clear-to-send level |
| txShutDone | input | 1 | Transmitter idle after being disabled |
| breakLevel | input | 1 | Break-detect state |
| evOverflow | input | 1 | Pulse: character lost to a full buffer |
| evStartBit | input | 1 | Pulse: start bit detected |
| evFrameErr | input | 1 | Pulse: stop bit missing |
| evParityErr | input | 1 | Pulse: parity mismatch |
| evNoise | input | 1 | Pulse: disagreeing bit sample |
| irqOut | output | 1 | Interrupt request |

## Verification
A vector table runs through the main patterns:
- Single error pulses, then paired error pulses, which show that each pulse sets its own bit.
- Clearing writes with mixed ones and zeros, which show a selective clear apart from a blanket clear.
- Writes aimed at read-only bits and at the masked view, which show ignored writes apart from real effects.
- Enable-set and enable-clear patterns read back through both views, which show the mask being applied apart from the raw status.

Directed cases cover the remaining behaviour:
- Toggling every live input reads back each level bit.
- Clear-to-send and break edges are separated, which shows that each change flag follows its own input.
- A clearing write in the same cycle as an overflow pulse shows which one wins.
- Holding clear-to-send high through reset shows that the first sample does not count as a change.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int DATA_W = 32;
  localparam int FLAG_W = 16;
  localparam int ADDR_W = 6;

  // Byte offsets decoded by the control module
  localparam int OFS_STATUS = 'h08;
  localparam int OFS_EN_SET = 'h0C;
  localparam int OFS_EN_CLR = 'h10;
  localparam int OFS_MASKED = 'h24;

  // Bit positions of the status word
  localparam int B_RX_WAIT  = 0;
  localparam int B_RX_QUIET = 1;
  localparam int B_TX_SPACE = 2;
  localparam int B_TX_QUIET = 3;
  localparam int B_CTS      = 4;
  localparam int B_CTS_CHG  = 5;
  localparam int B_TX_SHUT  = 6;
  localparam int B_OVERFLOW = 8;
  localparam int B_BREAK    = 10;
  localparam int B_BRK_CHG  = 11;
  localparam int B_START    = 12;
  localparam int B_FRAME    = 13;
  localparam int B_PARITY   = 14;
  localparam int B_NOISE    = 15;

  localparam logic [FLAG_W-1:0] LIVE_MASK   = 16'h045F;
  localparam logic [FLAG_W-1:0] STICKY_MASK = 16'hF920;
  localparam logic [FLAG_W-1:0] IRQ_MASK    = 16'hF965;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_MASKED
  } rdSel_e;

  typedef struct packed {
    logic   clearFlags;
    logic   enableSet;
    logic   enableClear;
    rdSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  output ctrlStrobe_t   strobe
);
  localparam logic [AW-1:0] A_STATUS = AW'(OFS_STATUS);
  localparam logic [AW-1:0] A_EN_SET = AW'(OFS_EN_SET);
  localparam logic [AW-1:0] A_EN_CLR = AW'(OFS_EN_CLR);
  localparam logic [AW-1:0] A_MASKED = AW'(OFS_MASKED);

  always_comb begin
    strobe             = '0;
    strobe.rdSel       = SEL_NONE;
    strobe.clearFlags  = busWrEn && (busAddr == A_STATUS);
    strobe.enableSet   = busWrEn && (busAddr == A_EN_SET);
    strobe.enableClear = busWrEn && (busAddr == A_EN_CLR);
    unique case (busAddr)
      A_STATUS:           strobe.rdSel = SEL_STATUS;
      A_EN_SET, A_EN_CLR: strobe.rdSel = SEL_ENABLE;
      A_MASKED:           strobe.rdSel = SEL_MASKED;
      default:            strobe.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/uart_flag_dp.sv
module uart_flag_dp
  import uart_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxDataWaiting,
  input  logic              rxLineQuiet,
  input  logic              txBufSpace,
  input  logic              txLineQuiet,
  input  logic              ctsLevel,
  input  logic              txShutDone,
  input  logic              breakLevel,
  input  logic              evOverflow,
  input  logic              evStartBit,
  input  logic              evFrameErr,
  input  logic              evParityErr,
  input  logic              evNoise,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [FLAG_W-1:0] liveVec, setVec, clrVec, stickyQ, enableQ;
  logic [FLAG_W-1:0] statusWord, maskedWord;
  logic ctsPrev, ctsPrimed, brkPrev;

  // Change detection history; the first sample after reset only primes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctsPrev   <= 1'b0;
      ctsPrimed <= 1'b0;
      brkPrev   <= 1'b0;
    end else begin
      ctsPrev   <= ctsLevel;
      ctsPrimed <= 1'b1;
      brkPrev   <= breakLevel;
    end
  end

  always_comb begin
    liveVec             = '0;
    liveVec[B_RX_WAIT]  = rxDataWaiting;
    liveVec[B_RX_QUIET] = rxLineQuiet;
    liveVec[B_TX_SPACE] = txBufSpace;
    liveVec[B_TX_QUIET] = txLineQuiet;
    liveVec[B_CTS]      = ctsLevel;
    liveVec[B_TX_SHUT]  = txShutDone;
    liveVec[B_BREAK]    = breakLevel;

    setVec              = '0;
    setVec[B_CTS_CHG]   = ctsPrimed && (ctsLevel != ctsPrev);
    setVec[B_OVERFLOW]  = evOverflow;
    setVec[B_BRK_CHG]   = breakLevel != brkPrev;
    setVec[B_START]     = evStartBit;
    setVec[B_FRAME]     = evFrameErr;
    setVec[B_PARITY]    = evParityErr;
    setVec[B_NOISE]     = evNoise;

    clrVec = strobe.clearFlags ? wrData[FLAG_W-1:0] : '0;
  end

  // One flop per sticky position; other positions are tied low
  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    if (STICKY_MASK[i]) begin : g_sticky
      always_ff @(posedge clk) begin
        if (!rstN) stickyQ[i] <= 1'b0;
        else       stickyQ[i] <= (stickyQ[i] && !clrVec[i]) || setVec[i];
      end
    end else begin : g_none
      assign stickyQ[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   enableQ <= '0;
    else if (strobe.enableSet)   enableQ <= enableQ | (wrData[FLAG_W-1:0] & IRQ_MASK);
    else if (strobe.enableClear) enableQ <= enableQ & ~wrData[FLAG_W-1:0];
  end

  assign statusWord = (liveVec & LIVE_MASK) | stickyQ;
  assign maskedWord = statusWord & enableQ;
  assign irqOut     = |maskedWord;

  always_comb begin
    unique case (strobe.rdSel)
      SEL_STATUS: rdData = DATA_W'(statusWord);
      SEL_ENABLE: rdData = DATA_W'(enableQ);
      SEL_MASKED: rdData = DATA_W'(maskedWord);
      default:    rdData = '0;
    endcase
  end

  // R3: an error pulse shows up after the next edge and is held
  p_error_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    evFrameErr |=> statusWord[B_FRAME]);
  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[B_OVERFLOW] && !clrVec[B_OVERFLOW]) |=> statusWord[B_OVERFLOW]);
  // R4: a clear-to-send change is captured
  p_cts_change_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctsPrimed && (ctsLevel != ctsPrev)) |=> statusWord[B_CTS_CHG]);
  // R5: a clearing write without a set removes the flag
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearFlags && wrData[B_FRAME] && !evFrameErr) |=> !statusWord[B_FRAME]);
  // R6: set beats clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (evOverflow && clrVec[B_OVERFLOW]) |=> statusWord[B_OVERFLOW]);
  // R7: enable-clear leaves none of the written bits enabled
  p_en_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enableClear |=> ((enableQ & $past(wrData[FLAG_W-1:0])) == '0));
  // R9: an enabled sticky flag raises the interrupt
  p_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|(stickyQ & enableQ)) |-> irqOut);
endmodule

// File: rtl/uart_flag_regs.sv
module uart_flag_regs
  import uart_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              rxDataWaiting,
  input  logic              rxLineQuiet,
  input  logic              txBufSpace,
  input  logic              txLineQuiet,
  input  logic              ctsLevel,
  input  logic              txShutDone,
  input  logic              breakLevel,
  input  logic              evOverflow,
  input  logic              evStartBit,
  input  logic              evFrameErr,
  input  logic              evParityErr,
  input  logic              evNoise,
  output logic              irqOut
);
  ctrlStrobe_t strobe;

  uart_flag_ctrl #(.AW(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  uart_flag_dp u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrData        (busWrData),
    .rxDataWaiting (rxDataWaiting),
    .rxLineQuiet   (rxLineQuiet),
    .txBufSpace    (txBufSpace),
    .txLineQuiet   (txLineQuiet),
    .ctsLevel      (ctsLevel),
    .txShutDone    (txShutDone),
    .breakLevel    (breakLevel),
    .evOverflow    (evOverflow),
    .evStartBit    (evStartBit),
    .evFrameErr    (evFrameErr),
    .evParityErr   (evParityErr),
    .evNoise       (evNoise),
    .rdData        (busRdData),
    .irqOut        (irqOut)
  );

  // R10: reserved upper half never reads non-zero
  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[DATA_W-1:16] == '0);
endmodule

// File: tb/sim_uart_flag_regs.sv
`timescale 1ns/1ps
module sim_uart_flag_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic rxDataWaiting = 0, rxLineQuiet = 1, txBufSpace = 1, txLineQuiet = 1;
  logic ctsLevel = 0, txShutDone = 0, breakLevel = 0;
  logic evOverflow = 0, evStartBit = 0, evFrameErr = 0, evParityErr = 0, evNoise = 0;
  logic irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_flag_regs u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .rxDataWaiting(rxDataWaiting), .rxLineQuiet(rxLineQuiet),
    .txBufSpace(txBufSpace), .txLineQuiet(txLineQuiet), .ctsLevel(ctsLevel),
    .txShutDone(txShutDone), .breakLevel(breakLevel),
    .evOverflow(evOverflow), .evStartBit(evStartBit), .evFrameErr(evFrameErr),
    .evParityErr(evParityErr), .evNoise(evNoise), .irqOut(irqOut)
  );

  // ev bits: {noise, parity, frame, start, overflow}
  typedef struct packed {
    logic        wr;
    logic [5:0]  addr;
    logic [15:0] wdata;
    logic [4:0]  ev;
    logic [5:0]  raddr;
    logic [15:0] exp;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  // live levels during the table give 0x000E
  localparam vec_t VECS [16] = '{
    '{1'b0, 6'h00, 16'h0000, 5'b00000, 6'h08, 16'h000E, 1'b0, 4'd1},  // R1
    '{1'b0, 6'h00, 16'h0000, 5'b00000, 6'h0C, 16'h0000, 1'b0, 4'd1},  // R1
    '{1'b0, 6'h00, 16'h0000, 5'b00001, 6'h08, 16'h010E, 1'b0, 4'd3},  // R3
    '{1'b0, 6'h00, 16'h0000, 5'b10100, 6'h08, 16'hA10E, 1'b0, 4'd3},  // R3
    '{1'b1, 6'h08, 16'h0100, 5'b00000, 6'h08, 16'hA00E, 1'b0, 4'd5},  // R5
    '{1'b1, 6'h08, 16'h005F, 5'b00000, 6'h08, 16'hA00E, 1'b0, 4'd2},  // R2
    '{1'b1, 6'h0C, 16'hFFFF, 5'b00000, 6'h0C, 16'hF965, 1'b1, 4'd7},  // R7
    '{1'b0, 6'h00, 16'h0000, 5'b00000, 6'h24, 16'hA004, 1'b1, 4'd8},  // R8
    '{1'b1, 6'h10, 16'h0004, 5'b00000, 6'h10, 16'hF961, 1'b1, 4'd7},  // R7
    '{1'b1, 6'h24, 16'hFFFF, 5'b00000, 6'h24, 16'hA000, 1'b1, 4'd8},  // R8
    '{1'b1, 6'h08, 16'hA000, 5'b00000, 6'h24, 16'h0000, 1'b0, 4'd9},  // R9
    '{1'b0, 6'h00, 16'h0000, 5'b01010, 6'h24, 16'h5000, 1'b1, 4'd9},  // R9
    '{1'b1, 6'h10, 16'hFFFF, 5'b00000, 6'h24, 16'h0000, 1'b0, 4'd7},  // R7
    '{1'b0, 6'h00, 16'h0000, 5'b00000, 6'h08, 16'h500E, 1'b0, 4'd5},  // R5
    '{1'b1, 6'h08, 16'hFFFF, 5'b00000, 6'h08, 16'h000E, 1'b0, 4'd5},  // R5
    '{1'b0, 6'h00, 16'h0000, 5'b00000, 6'h30, 16'h0000, 1'b0, 4'd10}  // R10
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    tick();
    busWrEn = 1'b0; busWrData = '0;
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    foreach (VECS[i]) begin
      @(negedge clk);
      busWrEn   = VECS[i].wr;
      busAddr   = VECS[i].addr;
      busWrData = 32'(VECS[i].wdata);
      {evNoise, evParityErr, evFrameErr, evStartBit, evOverflow} = VECS[i].ev;
      tick();
      busWrEn = 1'b0; busWrData = '0;
      {evNoise, evParityErr, evFrameErr, evStartBit, evOverflow} = '0;
      busAddr = VECS[i].raddr;
      #1;
      check($sformatf("R%0d row%0d data", VECS[i].req, i), busRdData, 32'(VECS[i].exp));
      check($sformatf("R%0d row%0d irq", VECS[i].req, i), 32'(irqOut), 32'(VECS[i].irq));
    end

    // R2: live levels appear in the same cycle
    @(negedge clk);
    busAddr = 6'h08;
    rxDataWaiting = 1; rxLineQuiet = 0; txBufSpace = 0; txLineQuiet = 0;
    ctsLevel = 1; txShutDone = 1; breakLevel = 1;
    #1;
    check("R2 live levels", busRdData & 32'h045F, 32'h0451);

    // R4: both change flags after the next edge
    @(negedge clk); #1;
    check("R4 cts+break change", busRdData & 32'h0820, 32'h0820);

    // R5: clear both, no further change keeps them clear
    @(negedge clk);
    busWrite(6'h08, 32'h0820);
    busAddr = 6'h08; #1;
    check("R5 change flags cleared", busRdData & 32'h0820, 32'h0000);
    @(negedge clk); #1;
    check("R4 steady levels stay clear", busRdData & 32'h0820, 32'h0000);

    // R4: only clear-to-send changes
    @(negedge clk);
    ctsLevel = 0;
    tick(); #1;
    check("R4 cts alone", busRdData & 32'h0820, 32'h0020);

    // R6: overflow pulse together with its clearing write
    @(negedge clk);
    evOverflow = 1'b1;
    busWrite(6'h08, 32'h0100);
    evOverflow = 1'b0;
    busAddr = 6'h08; #1;
    check("R6 set beats clear", busRdData & 32'h0100, 32'h0100);

    // R1: reset with clear-to-send held high, enables and flags set beforehand
    @(negedge clk);
    busWrite(6'h0C, 32'hFFFF);
    rxDataWaiting = 0; rxLineQuiet = 1; txBufSpace = 1; txLineQuiet = 1;
    ctsLevel = 1; txShutDone = 0; breakLevel = 0;
    rstN = 1'b0;
    repeat (2) tick();
    rstN = 1'b1;
    repeat (3) tick();
    busAddr = 6'h08; #1;
    check("R1 status after reset (R4 no first-sample change)", busRdData, 32'h001E);
    busAddr = 6'h0C; #1;
    check("R1 enable after reset", busRdData, 32'h0000);
    check("R1 irq after reset", 32'(irqOut), 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule